// File: doc/BRIEF.md
# PLL Retune Clock Switch Sequencer

This block steps a CPU core clock from one PLL setting to another without ever clocking the core from a PLL that is being reprogrammed. When a retune request comes in with a new input divider, feedback multiplier, output divider and three bus divider codes, the sequencer works through a fixed order. First it moves the core onto a backup clock source and forces the bus clock divider to a safe code. It then writes the new PLL fields and waits a fixed settling time. After that it polls a lock input, with a bounded timeout. Once lock is seen, the core goes back to the main PLL and the new bus dividers are applied together. Only then does the PLL leave slow mode and enter normal output mode.

The PLL output is 24 MHz × multiplier / (input divider × output divider). The sequencer does not compute this rate. It only passes the three fields through. One setting (input divider 1, multiplier 64, output divider 8) is the power-down code. For that setting the sequencer parks the core, writes the fields, raises the power-down flag and finishes without waiting for lock. The analog PLL is outside the block, and the `pll_lock` input stands in for it. Other logic in the clock unit takes the register-style outputs.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset: `busy`, `done` and `err` are 0. `core_sel` is 1 (backup source). `aclk_div` equals the safe code SAFE_ACLK (default 3). `pll_nr`/`pll_nf`/`pll_no` hold the power-down code 1/64/8. `pll_pd` is 1 and `pll_normal` is 0.
- R2: A request accepted while idle sets `core_sel` to 1 (encoding: 1 = backup source, 0 = main PLL), sets `aclk_div` to SAFE_ACLK and clears `pll_normal`. All three change in the same cycle, two cycles after the request edge.
- R3: The PLL fields change only after the core is parked. They take the requested NR, NF and NO unchanged one cycle after the park write.
- R4: After the PLL fields are written, `pll_lock` is ignored for at least SETTLE_CYC cycles. Even with lock held high, `core_sel` falls no earlier than SETTLE_CYC+6 cycles after the request edge.
- R5: After lock, `core_sel` returns to 0 and all three bus dividers take the requested codes in the same cycle.
- R6: `pll_normal` rises strictly after `core_sel` has fallen to 0, and is never 1 while `core_sel` is 1.
- R7: `done` is a one-cycle pulse that comes after normal mode is entered. `busy` stays high from the cycle after the request until the `done` cycle.
- R8: If lock does not arrive within LOCK_TIMEOUT polling cycles, `err` pulses for one cycle and no `done` is given. The core stays on the backup source and `pll_normal` stays 0.
- R9: A request with the power-down code (1/64/8) sets `pll_pd` to 1, leaves the core on the backup source with `pll_normal` at 0, and pulses `done` without waiting for lock. Any other setting clears `pll_pd`.
- R10: A request that arrives while `busy` is high is ignored. The outputs end with the first setting, only one `done` pulse is given, and no new sequence starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Retune request, sampled while idle |
| cfg_nr | input | 5 | Requested input divider |
| cfg_nf | input | 7 | Requested feedback multiplier |
| cfg_no | input | 4 | Requested output divider |
| cfg_aclk | input | 2 | Requested core-to-bus divider code |
| cfg_hclk | input | 2 | Requested bus-to-AHB divider code |
| cfg_pclk | input | 2 | Requested bus-to-APB divider code |
| pll_lock | input | 1 | Lock indication from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle lock timeout pulse |
| core_sel | output | 1 | Core parent select: 1 backup, 0 main PLL |
| aclk_div | output | 2 | Applied core-to-bus divider code |
| hclk_div | output | 2 | Applied AHB divider code |
| pclk_div | output | 2 | Applied APB divider code |
| pll_nr | output | 5 | Programmed input divider |
| pll_nf | output | 7 | Programmed feedback multiplier |
| pll_no | output | 4 | Programmed output divider |
| pll_pd | output | 1 | PLL power-down flag |
| pll_normal | output | 1 | PLL in normal (not slow) output mode |

## Verification
The assertions assume that `rst` is held for at least one clock before any check is needed. They also assume that `pll_lock` and `req` are clean synchronous levels. They do not assume that lock stays high once it has risen, because a lock loss after the poll has no effect on the order of writes. The bench keeps to these assumptions. It changes every input only on the falling clock edge, holds reset for several cycles, and raises lock only by a single step at a chosen cycle count. To cover both the settling window and the timeout, it either holds lock high from the start or never raises it.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int NR_W  = 5;
    localparam int NF_W  = 7;
    localparam int NO_W  = 4;
    localparam int DIV_W = 2;

    typedef struct packed {
        logic [NR_W-1:0] nr;
        logic [NF_W-1:0] nf;
        logic [NO_W-1:0] no;
    } pll_cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] aclk;
        logic [DIV_W-1:0] hclk;
        logic [DIV_W-1:0] pclk;
    } bus_div_t;

    typedef struct packed {
        pll_cfg_t pll;
        bus_div_t bus;
    } retune_req_t;

    typedef struct packed {
        logic park;
        logic prog;
        logic ret;
        logic norm;
    } wr_strobe_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK,
        ST_PROG,
        ST_SETTLE,
        ST_LOCK,
        ST_RETURN,
        ST_NORMAL,
        ST_FIN,
        ST_FAIL
    } seq_state_t;

    localparam pll_cfg_t PD_CFG = '{nr: NR_W'(1), nf: NF_W'(64), no: NO_W'(8)};

    function automatic logic is_pwrdn(pll_cfg_t c);
        return c == PD_CFG;
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

    // once run out, the timer stays at zero until reloaded
    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired); // R4

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int SETTLE_CYC   = 16,
    parameter int LOCK_TIMEOUT = 2400000,
    parameter int CNT_W        = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  retune_req_t      cfg_in,
    input  logic             lock,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output wr_strobe_t       wr,
    output retune_req_t      cfg_q,
    output logic             busy,
    output logic             done,
    output logic             err
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req) begin
                cfg_q <= cfg_in;
            end
        end
    end

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:   if (req) nxt = ST_PARK;
            ST_PARK:   nxt = ST_PROG;
            ST_PROG: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETTLE_CYC);
                nxt      = is_pwrdn(cfg_q.pll) ? ST_FIN : ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LOCK_TIMEOUT);
                    nxt      = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (lock)             nxt = ST_RETURN;
                else if (tmr_expired) nxt = ST_FAIL;
            end
            ST_RETURN: nxt = ST_NORMAL;
            ST_NORMAL: nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            ST_FAIL:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign wr.park = (state == ST_PARK);
    assign wr.prog = (state == ST_PROG);
    assign wr.ret  = (state == ST_RETURN);
    assign wr.norm = (state == ST_NORMAL);
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);
    assign err     = (state == ST_FAIL);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R8
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
    import pll_seq_pkg::*;
#(
    parameter logic [DIV_W-1:0] SAFE_ACLK = 2'd3
) (
    input  logic        clk,
    input  logic        rst,
    input  wr_strobe_t  wr,
    input  retune_req_t cfg_q,
    output logic        core_sel,
    output bus_div_t    div,
    output pll_cfg_t    pll,
    output logic        pd,
    output logic        normal
);
    always_ff @(posedge clk) begin
        if (rst) begin
            core_sel <= 1'b1;
            div      <= '{aclk: SAFE_ACLK, hclk: '0, pclk: '0};
            pll      <= PD_CFG;
            pd       <= 1'b1;
            normal   <= 1'b0;
        end else begin
            if (wr.park) begin
                core_sel <= 1'b1;
                div.aclk <= SAFE_ACLK;
                normal   <= 1'b0;
            end
            if (wr.prog) begin
                pll <= cfg_q.pll;
                pd  <= is_pwrdn(cfg_q.pll);
            end
            if (wr.ret) begin
                core_sel <= 1'b0;
                div      <= cfg_q.bus;
            end
            if (wr.norm) begin
                normal <= 1'b1;
            end
        end
    end

    AST_PARK_SAFE: assert property (@(posedge clk) disable iff (rst)
        $rose(core_sel) |-> (div.aclk == SAFE_ACLK && !normal)); // R2
    AST_PROG_PARKED: assert property (@(posedge clk) disable iff (rst)
        wr.prog |-> (core_sel && div.aclk == SAFE_ACLK)); // R3
    AST_NORMAL_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
        normal |-> !core_sel); // R6
    AST_NORMAL_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
        $rose(normal) |-> !$past(core_sel)); // R6

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int               SETTLE_CYC   = 16,
    parameter int               LOCK_TIMEOUT = 2400000,
    parameter logic [DIV_W-1:0] SAFE_ACLK    = 2'd3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [NR_W-1:0] cfg_nr,
    input  logic [NF_W-1:0] cfg_nf,
    input  logic [NO_W-1:0] cfg_no,
    input  logic [DIV_W-1:0] cfg_aclk,
    input  logic [DIV_W-1:0] cfg_hclk,
    input  logic [DIV_W-1:0] cfg_pclk,
    input  logic            pll_lock,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            core_sel,
    output logic [DIV_W-1:0] aclk_div,
    output logic [DIV_W-1:0] hclk_div,
    output logic [DIV_W-1:0] pclk_div,
    output logic [NR_W-1:0] pll_nr,
    output logic [NF_W-1:0] pll_nf,
    output logic [NO_W-1:0] pll_no,
    output logic            pll_pd,
    output logic            pll_normal
);
    localparam int MAX_WAIT = (LOCK_TIMEOUT > SETTLE_CYC) ? LOCK_TIMEOUT : SETTLE_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    retune_req_t      cfg_in, cfg_q;
    wr_strobe_t       wr;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    bus_div_t         div;
    pll_cfg_t         pll;

    assign cfg_in = '{pll: '{nr: cfg_nr, nf: cfg_nf, no: cfg_no},
                      bus: '{aclk: cfg_aclk, hclk: cfg_hclk, pclk: cfg_pclk}};

    pll_seq_fsm #(
        .SETTLE_CYC  (SETTLE_CYC),
        .LOCK_TIMEOUT(LOCK_TIMEOUT),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cfg_in     (cfg_in),
        .lock       (pll_lock),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .wr         (wr),
        .cfg_q      (cfg_q),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    pll_seq_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    pll_seq_regs #(
        .SAFE_ACLK(SAFE_ACLK)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .cfg_q   (cfg_q),
        .core_sel(core_sel),
        .div     (div),
        .pll     (pll),
        .pd      (pll_pd),
        .normal  (pll_normal)
    );

    assign aclk_div = div.aclk;
    assign hclk_div = div.hclk;
    assign pclk_div = div.pclk;
    assign pll_nr   = pll.nr;
    assign pll_nf   = pll.nf;
    assign pll_no   = pll.no;

    AST_ERR_ON_BACKUP: assert property (@(posedge clk) disable iff (rst)
        err |-> (core_sel && !pll_normal && !done)); // R8

endmodule

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb;
    import pll_seq_pkg::*;

    localparam int SETTLE = 8;
    localparam int TMO    = 200;
    localparam int SAFE   = 3;
    localparam int NEVER  = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [NR_W-1:0] cfg_nr = '0;
    logic [NF_W-1:0] cfg_nf = '0;
    logic [NO_W-1:0] cfg_no = '0;
    logic [DIV_W-1:0] cfg_aclk = '0, cfg_hclk = '0, cfg_pclk = '0;
    logic pll_lock = 1'b0;
    logic busy, done, err, core_sel, pll_pd, pll_normal;
    logic [DIV_W-1:0] aclk_div, hclk_div, pclk_div;
    logic [NR_W-1:0] pll_nr;
    logic [NF_W-1:0] pll_nf;
    logic [NO_W-1:0] pll_no;

    always #2 clk = ~clk; // 250 MHz

    pll_retune_seq #(
        .SETTLE_CYC  (SETTLE),
        .LOCK_TIMEOUT(TMO),
        .SAFE_ACLK   (2'(SAFE))
    ) u_dut (
        .clk(clk), .rst(rst), .req(req),
        .cfg_nr(cfg_nr), .cfg_nf(cfg_nf), .cfg_no(cfg_no),
        .cfg_aclk(cfg_aclk), .cfg_hclk(cfg_hclk), .cfg_pclk(cfg_pclk),
        .pll_lock(pll_lock),
        .busy(busy), .done(done), .err(err), .core_sel(core_sel),
        .aclk_div(aclk_div), .hclk_div(hclk_div), .pclk_div(pclk_div),
        .pll_nr(pll_nr), .pll_nf(pll_nf), .pll_no(pll_no),
        .pll_pd(pll_pd), .pll_normal(pll_normal)
    );

    // nr, nf, no, aclk, hclk, pclk, lock delay
    localparam int NVEC = 4;
    localparam logic [29:0] VEC [NVEC] = '{
        {5'd1, 7'd50, 4'd1, 2'd1, 2'd2, 2'd3, 8'd0},
        {5'd2, 7'd98, 4'd1, 2'd2, 2'd1, 2'd0, 8'd30},
        {5'd1, 7'd52, 4'd2, 2'd0, 2'd1, 2'd1, 8'd5},
        {5'd1, 7'd38, 4'd1, 2'd1, 2'd0, 2'd2, 8'd100}
    };

    int errors = 0;
    int total  = 0;
    bit finished = 0;

    // observations from one sequence
    int n_done, n_err, done_cnt, t_ret, t_norm;
    bit busy_gap;
    int s2_cs, s2_aclk, s2_nm, s2_nr, s2_nf, s2_no;
    int s3_nr, s3_nf, s3_no;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input int nr, input int nf, input int no, input int a,
                           input int h, input int p, input int dly, input bit intrude);
        bit prev_cs, prev_nm;
        int n;
        @(negedge clk);
        cfg_nr = NR_W'(nr); cfg_nf = NF_W'(nf); cfg_no = NO_W'(no);
        cfg_aclk = DIV_W'(a); cfg_hclk = DIV_W'(h); cfg_pclk = DIV_W'(p);
        pll_lock = (dly == 0);
        req = 1'b1;
        prev_cs = core_sel; prev_nm = pll_normal;
        n_done = -1; n_err = -1; done_cnt = 0; t_ret = -1; t_norm = -1; busy_gap = 0;
        n = 0;
        while (n < 2000 && n_done < 0 && n_err < 0) begin
            @(negedge clk);
            n++;
            if (n == 1) req = 1'b0;
            if (intrude && n == 3) begin
                req = 1'b1;
                cfg_nr = 5'd1; cfg_nf = 7'd46; cfg_no = 4'd1;
                cfg_aclk = 2'd3; cfg_hclk = 2'd3; cfg_pclk = 2'd3;
            end
            if (intrude && n == 4) req = 1'b0;
            pll_lock = (dly != NEVER) && (n >= dly);
            if (!busy) busy_gap = 1;
            if (done) begin done_cnt++; n_done = n; end
            if (err) n_err = n;
            if (prev_cs && !core_sel) t_ret = n;
            if (!prev_nm && pll_normal) t_norm = n;
            prev_cs = core_sel; prev_nm = pll_normal;
            if (n == 2) begin
                s2_cs = core_sel; s2_aclk = aclk_div; s2_nm = pll_normal;
                s2_nr = pll_nr; s2_nf = pll_nf; s2_no = pll_no;
            end
            if (n == 3) begin
                s3_nr = pll_nr; s3_nf = pll_nf; s3_no = pll_no;
            end
        end
        req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        int pnr, pnf, pno;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err, "R1 handshake idle", {busy, done, err}, 0);
        chk(core_sel == 1'b1, "R1 core on backup", core_sel, 1);
        chk(aclk_div == SAFE, "R1 safe aclk", aclk_div, SAFE);
        chk(pll_nr == 1 && pll_nf == 64 && pll_no == 8, "R1 pll pd code", pll_nf, 64);
        chk(pll_pd && !pll_normal, "R1 pd and slow mode", {pll_pd, pll_normal}, 2);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            int vnr, vnf, vno, va, vh, vp, vd;
            {vnr, vnf, vno, va, vh, vp, vd} = {27'd0, VEC[i][29:25], 25'd0, VEC[i][24:18],
                                               28'd0, VEC[i][17:14], 30'd0, VEC[i][13:12],
                                               30'd0, VEC[i][11:10], 30'd0, VEC[i][9:8],
                                               24'd0, VEC[i][7:0]};
            pnr = pll_nr; pnf = pll_nf; pno = pll_no;
            run_seq(vnr, vnf, vno, va, vh, vp, vd, 1'b0);
            chk(s2_cs == 1 && s2_aclk == SAFE && s2_nm == 0, "R2 park write", s2_aclk, SAFE);
            chk(s2_nr == pnr && s2_nf == pnf && s2_no == pno, "R3 fields held at park", s2_nf, pnf);
            chk(s3_nr == vnr && s3_nf == vnf && s3_no == vno, "R3 fields written", s3_nf, vnf);
            chk(t_ret >= SETTLE + 6, "R4 settle before lock poll", t_ret, SETTLE + 6);
            chk(core_sel == 0 && aclk_div == va && hclk_div == vh && pclk_div == vp,
                "R5 return and dividers", {aclk_div, hclk_div, pclk_div}, {va[1:0], vh[1:0], vp[1:0]});
            chk(t_norm > t_ret && pll_normal, "R6 normal after return", t_norm, t_ret + 1);
            chk(done_cnt == 1 && n_done == t_norm && !busy_gap, "R7 done and busy", n_done, t_norm);
            chk(n_err < 0 && !pll_pd, "R9 pd cleared", pll_pd, 0);
            @(negedge clk);
            chk(!done && !busy, "R7 done one cycle", done, 0);
        end

        // request while busy
        run_seq(2, 98, 1, 2, 1, 0, 0, 1'b1);
        chk(pll_nr == 2 && pll_nf == 98 && pll_no == 1, "R10 first setting kept", pll_nf, 98);
        chk(aclk_div == 2 && hclk_div == 1 && pclk_div == 0, "R10 first dividers kept", aclk_div, 2);
        begin
            bit extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (busy || done) extra = 1;
            end
            chk(!extra && done_cnt == 1, "R10 no second sequence", extra, 0);
        end

        // lock timeout
        run_seq(1, 44, 1, 1, 1, 1, NEVER, 1'b0);
        chk(n_err >= TMO + SETTLE + 3 && n_err <= TMO + SETTLE + 8, "R8 timeout length", n_err, TMO + SETTLE + 5);
        chk(n_done < 0 && core_sel && !pll_normal, "R8 stays on backup", core_sel, 1);
        @(negedge clk);
        chk(!err && !busy, "R8 err one cycle", err, 0);

        // power-down code
        run_seq(1, 64, 8, 0, 0, 0, NEVER, 1'b0);
        chk(n_done == 3 && n_err < 0, "R9 done without lock", n_done, 3);
        chk(pll_pd && core_sel && !pll_normal, "R9 pd on backup", {pll_pd, core_sel, pll_normal}, 6);
        @(negedge clk);

        run_seq(1, 52, 2, 0, 1, 1, 0, 1'b0);
        chk(!pll_pd && pll_normal && !core_sel, "R9 pd cleared by normal setting", pll_pd, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule